// File: doc/BRIEF.md
# Sticky Status Register with Maskable Interrupt

This block gathers the status indications of a bit-error test receiver into one register that a processor reads. Bit 0 follows the receiver's synchronization state live. The bits above it are sticky. One group records one-shot events: a detected bit error, an overflow of the bit counter and an overflow of the error counter. The other group records alarm conditions: loss of receive sync, an all-zeros pattern and an all-ones pattern. A read of the status register clears the sticky bits, and each group follows its own clearing rule.

A mask register uses the same bit layout as the status register. The active-low interrupt output is pulled low while any status bit is set and its mask bit is 1. A small register port gives a clearing read of the status register and read/write access to the mask. Read data comes out registered, one cycle after the read strobe. Other logic generates the events and alarms. They arrive here as input levels.

Top module: `bert_status_irq`

## Requirements
- R1: Status bit 0 shows `sync_i` as sampled in the cycle of the read. It is not latched, and it drives the interrupt logic combinationally.
- R2: Event bits 1 to N_EVT, with `evt_i[k]` mapped to bit 1+k, set on a rising edge of their input and stay set until a status read.
- R3: A status read clears every event bit. An event input that stays high does not set the bit again. Only a new rising edge does.
- R4: Alarm bits, with `alm_i[k]` mapped to bit 1+N_EVT+k, set in every cycle their input is high and stay set until a status read.
- R5: A status read clears an alarm bit only if its input is low in the read cycle. Otherwise the bit stays set.
- R6: An event edge that arrives in the same cycle as a status read leaves its bit set. The read data shows the value from before that cycle.
- R7: Asserting `reg_rd` loads `reg_rdata` at the next clock edge, with the status register for `reg_addr`=0 and the mask for `reg_addr`=1. Reading the mask clears nothing. A write to address 0 has no effect.
- R8: A write with `reg_addr`=1 loads the mask, and reading it back returns the value written. After reset the mask is all zeros, so no interrupt is possible.
- R9: `irq_n` is 0 exactly when some status bit is 1 and its mask bit is also 1. A mask bit of 1 enables that source.
- R10: Reset clears all sticky bits, the event-edge history and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Live synchronization state |
| evt_i | input | N_EVT | Event inputs, edge-detected |
| alm_i | input | N_ALM | Alarm condition levels |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | N_EVT+N_ALM+1 | Write data |
| reg_rdata | output | N_EVT+N_ALM+1 | Registered read data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The central stimulus is an event input and an alarm input each held high across two back-to-back status reads. This is the only pattern that separates the two clearing rules: the event bit must drop and the alarm bit must stay. Single-cycle event pulses and an edge that lands in the same cycle as a read check that no occurrence is lost and that the read returns the pre-read value. A mix of alarms where one drops before the read and another persists shows that each bit is cleared on its own. Mask values that enable only the sync bit, only an alarm bit, all sources or none separate correct gating from an interrupt that ignores the mask or the live bit.

// File: rtl/bert_stat_pkg.sv
package bert_stat_pkg;

   // Clearing class of a bank of sticky status bits
   typedef enum logic {
      KIND_EVENT = 1'b0,   // cleared by any status read
      KIND_ALARM = 1'b1    // cleared by a read only when the condition is gone
   } lat_kind_e;

   localparam int unsigned SYNC_POS = 0;
   localparam int unsigned MAX_STAT_W = 32;

endpackage

// File: rtl/stat_latch_bank.sv
module stat_latch_bank
   import bert_stat_pkg::*;
#(
   parameter int unsigned N    = 3,
   parameter lat_kind_e   KIND = KIND_EVENT,
   parameter bit          EDGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [N-1:0] src_i,
   output logic [N-1:0] lat_o
);

   logic [N-1:0] lat_q;
   logic [N-1:0] set_v;

   generate
      if (N < 1) begin : g_bad_n
         $error("stat_latch_bank: N must be at least 1");
      end

      if (KIND == KIND_EVENT && EDGE) begin : g_edge
         logic [N-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= src_i;
         end
         assign set_v = src_i & ~prev_q;

         // R3: after a clearing read, a source that was already high stays clear
         p_held_no_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> ((lat_q & $past(src_i & prev_q)) == '0));
      end else begin : g_level
         assign set_v = src_i;
      end

      if (KIND == KIND_ALARM) begin : g_alarm_chk
         // R5: a condition still present during the read survives it
         p_alarm_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> ((lat_q & $past(src_i)) == $past(src_i)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= set_v | (lat_q & ~{N{clr_i}});
   end

   assign lat_o = lat_q;

   // R2: without a read, a set bit never drops
   p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   // R8: a write lands in the mask on the next edge
   p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_q == $past(wdata_i)));

   // R8: no write, no change
   p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_q));

endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
   parameter int unsigned W = 7
) (
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_n_o
);

   logic [W-1:0] hit;

   always_comb begin
      hit     = status_i & mask_i;
      irq_n_o = ~(|hit);
   end

endmodule

// File: rtl/bert_status_irq.sv
module bert_status_irq
   import bert_stat_pkg::*;
#(
   parameter int unsigned N_EVT    = 3,
   parameter int unsigned N_ALM    = 3,
   parameter bit          EVT_EDGE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sync_i,
   input  logic [N_EVT-1:0]       evt_i,
   input  logic [N_ALM-1:0]       alm_i,
   input  logic                   reg_addr,
   input  logic                   reg_rd,
   input  logic                   reg_wr,
   input  logic [N_EVT+N_ALM:0]   reg_wdata,
   output logic [N_EVT+N_ALM:0]   reg_rdata,
   output logic                   irq_n
);

   localparam int unsigned STAT_W  = N_EVT + N_ALM + 1;
   localparam int unsigned EVT_LSB = SYNC_POS + 1;
   localparam int unsigned ALM_LSB = EVT_LSB + N_EVT;

   generate
      if (STAT_W > MAX_STAT_W) begin : g_bad_w
         $error("bert_status_irq: status register wider than allowed");
      end
   endgenerate

   logic               rd_stat;
   logic               wr_mask;
   logic [N_EVT-1:0]   evt_lat;
   logic [N_ALM-1:0]   alm_lat;
   logic [STAT_W-1:0]  status_v;
   logic [STAT_W-1:0]  mask_v;
   logic [STAT_W-1:0]  rdata_q;

   assign rd_stat = reg_rd && (reg_addr == 1'b0);
   assign wr_mask = reg_wr && (reg_addr == 1'b1);

   stat_latch_bank #(.N(N_EVT), .KIND(KIND_EVENT), .EDGE(EVT_EDGE)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (rd_stat),
      .src_i (evt_i),
      .lat_o (evt_lat)
   );

   stat_latch_bank #(.N(N_ALM), .KIND(KIND_ALARM), .EDGE(1'b0)) u_alm (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (rd_stat),
      .src_i (alm_i),
      .lat_o (alm_lat)
   );

   stat_mask_reg #(.W(STAT_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_mask),
      .wdata_i (reg_wdata),
      .mask_o  (mask_v)
   );

   always_comb begin
      status_v                              = '0;
      status_v[SYNC_POS]                    = sync_i;
      status_v[EVT_LSB +: N_EVT]            = evt_lat;
      status_v[ALM_LSB +: N_ALM]            = alm_lat;
   end

   stat_irq_gen #(.W(STAT_W)) u_irq (
      .status_i (status_v),
      .mask_i   (mask_v),
      .irq_n_o  (irq_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= reg_addr ? mask_v : status_v;
   end

   assign reg_rdata = rdata_q;

   // R7: read data only changes on a read strobe
   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R9: an all-zero mask keeps the interrupt released
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_v == '0) |-> irq_n);

   // R7: reading the mask leaves every sticky bit in place
   p_mask_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr) |=> (((evt_lat & $past(evt_lat)) == $past(evt_lat)) &&
                                ((alm_lat & $past(alm_lat)) == $past(alm_lat))));

endmodule

// File: tb/bert_status_irq_test.sv
`timescale 1ns/1ps
module bert_status_irq_test;

   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sync_i = 1'b0;
   logic [2:0]   evt_i = '0;
   logic [2:0]   alm_i = '0;
   logic         reg_addr = 1'b0;
   logic         reg_rd = 1'b0;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         irq_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bert_status_irq uut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .evt_i(evt_i), .alm_i(alm_i),
      .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   // {sync, evt[2:0], alm[2:0], rd, exp_rdata[6:0], exp_irq_n}
   localparam logic [15:0] VEC [12] = '{
      16'b1_000_000_0_0000000_1,
      16'b1_001_000_0_0000000_0,
      16'b1_001_000_1_0000011_1,
      16'b1_001_000_1_0000001_1,
      16'b0_000_001_0_0000000_0,
      16'b0_000_001_1_0010000_0,
      16'b0_000_000_1_0010000_1,
      16'b0_010_000_1_0000000_0,
      16'b0_000_000_1_0000100_1,
      16'b1_100_110_0_0000000_0,
      16'b1_000_100_1_1101001_0,
      16'b0_000_000_1_1000000_1
   };

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [W-1:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [W-1:0] d);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 rdata after reset", reg_rdata, 7'h00);
      chk("R10 irq_n after reset", {6'd0, irq_n}, 7'h01);
      reg_read(1'b1, rd);
      chk("R8 mask resets to zero", rd, 7'h00);

      // R8: with the reset mask an event raises no interrupt
      evt_i = 3'b001; @(negedge clk); evt_i = 3'b000; @(negedge clk);
      chk("R8 zero mask blocks irq", {6'd0, irq_n}, 7'h01);
      reg_read(1'b0, rd);
      chk("R2 event pulse latched at bit1", rd, 7'h02);
      reg_read(1'b0, rd);
      chk("R3 event cleared by read", rd, 7'h00);

      reg_write(1'b1, 7'h7E);
      reg_read(1'b1, rd);
      chk("R8 mask readback", rd, 7'h7E);
      reg_write(1'b0, 7'h7F);
      reg_read(1'b0, rd);
      chk("R7 write to status ignored", rd, 7'h00);

      // Table walk: R1 R2 R3 R4 R5 R6 R9
      for (int i = 0; i < 12; i++) begin
         sync_i   = VEC[i][15];
         evt_i    = VEC[i][14:12];
         alm_i    = VEC[i][11:9];
         reg_addr = 1'b0;
         reg_rd   = VEC[i][8];
         @(negedge clk);
         if (VEC[i][8])
            chk($sformatf("table %0d rdata (R1 R2 R3 R4 R5 R6)", i), reg_rdata, VEC[i][7:1]);
         chk($sformatf("table %0d irq_n (R9)", i), {6'd0, irq_n}, {6'd0, VEC[i][0]});
      end
      reg_rd = 1'b0; sync_i = 1'b0; evt_i = '0; alm_i = '0;
      @(negedge clk);

      // R1: live sync bit reaches the interrupt without latching
      reg_write(1'b1, 7'h01);
      sync_i = 1'b1; #1;
      chk("R1 sync drives irq live", {6'd0, irq_n}, 7'h00);
      sync_i = 1'b0; #1;
      chk("R1 sync not latched", {6'd0, irq_n}, 7'h01);
      @(negedge clk);

      // R9: only enabled sources reach the interrupt
      reg_write(1'b1, 7'h10);
      evt_i = 3'b001; @(negedge clk); evt_i = 3'b000; @(negedge clk);
      chk("R9 masked event keeps irq high", {6'd0, irq_n}, 7'h01);
      alm_i = 3'b001; @(negedge clk);
      chk("R9 enabled alarm pulls irq low", {6'd0, irq_n}, 7'h00);
      reg_read(1'b1, rd);
      chk("R7 mask read value", rd, 7'h10);
      alm_i = 3'b000;
      reg_read(1'b0, rd);
      chk("R7 mask read cleared nothing", rd, 7'h12);
      chk("R9 irq released after clear", {6'd0, irq_n}, 7'h01);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule